// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block holds the peak winding current of a three-phase bridge below a limit by chopping the high-side drive. It receives a single trip bit from an external sense comparator, whose timing is not tied to the block clock. The bit is synchronized before use. While the bridge is driving, a trip switches the high side off for a programmable number of clock cycles. When that interval ends, the high side comes back on and a blanking window opens. During the blanking window, trips are ignored, so that switching transients cannot retrigger the chopper.

An external PWM command gates the high side directly. Holding the command high leaves the trip as the only limit on the current. Driving it low switches the high side off in the same way a trip does.

Whenever the high side is off, the block outputs a recirculation code. A downstream gate-select stage uses this code to decide which low-side switches stay on:
- Slow decay keeps the low sides of both active phases on.
- Fast decay keeps on only the low side opposite the selected one.

The off-time and blanking counts come from registers and are counted in clock cycles. A status output reports the current phase of the block: drive, off-time or blanking.

Top module: `chop_ctrl`

## Requirements
- R1: While in the drive phase (`state_o` = 2'b00) with `pwm_i` high, a trip presented before clock edge k switches `hs_en_o` off after edge k+2. The delay comes from two synchronizer stages plus the phase register, and the block then enters the off-time phase (`state_o` = 2'b01).
- R2: The off-time phase lasts exactly `off_cnt_i` cycles, using the value sampled when the phase is entered. It then moves to the blanking phase (`state_o` = 2'b10). `hs_en_o` is low throughout the off-time phase, whatever the state of `pwm_i`.
- R3: The blanking phase lasts exactly `blank_cnt_i` cycles with `pwm_i` high, using the value sampled on entry. It then moves to the drive phase. A trip seen during blanking or during off-time has no effect.
- R4: With `pwm_i` low, `hs_en_o` is low in the same cycle. Outside the off-time phase, the block is held in blanking with its count reloaded, so a rising `pwm_i` starts a full blanking window.
- R5: `recirc_o` is 2'b00 while `hs_en_o` is high. When `hs_en_o` is low, `recirc_o` is 2'b10 if `slow_decay_i` is 1 (both low sides on) and 2'b01 if `slow_decay_i` is 0 (only the opposite low side on).
- R6: `state_o` only ever takes the values 2'b00 (drive), 2'b01 (off-time) or 2'b10 (blanking).
- R7: While reset is asserted, the block is in the blanking phase with a one-cycle remaining count. `hs_en_o` then follows `pwm_i`.
- R8: A count of zero, for either the off-time or the blanking window, behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Current trip from the sense comparator, asynchronous to the clock |
| pwm_i | input | 1 | PWM command; high allows the high side to drive |
| slow_decay_i | input | 1 | 1 selects slow decay, 0 selects fast decay |
| off_cnt_i | input | CW | Off-time length in cycles (0 behaves as 1) |
| blank_cnt_i | input | CW | Blanking length in cycles (0 behaves as 1) |
| hs_en_o | output | 1 | High-side enable for the switch chosen by commutation |
| recirc_o | output | 2 | Recirculation code: 00 none, 01 fast, 10 slow |
| state_o | output | 2 | Phase: 00 drive, 01 off-time, 10 blanking |

## Verification
The assertions assume that `pwm_i`, `slow_decay_i` and both count inputs are synchronous to `clk_i`. Only `trip_i` is allowed to arrive at any time. They also take the counts as sampled at the moment a phase is entered, so changing a count in the middle of a window does not count as a violation.

The stimulus drives every input half a cycle away from the active edge. It changes the counts only now and then, within a small range that includes zero, and toggles PWM in runs so that drive, off-time and blanking phases all occur many times.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_DRIVE = 2'b00,
    ST_OFF   = 2'b01,
    ST_BLANK = 2'b10
  } chop_st_e;

  typedef enum logic [1:0] {
    RC_NONE = 2'b00,
    RC_FAST = 2'b01,
    RC_SLOW = 2'b10
  } recirc_e;
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/chop_out.sv
module chop_out
  import chop_pkg::*;
(
  input  logic       hs_allow_i,
  input  logic       pwm_i,
  input  logic       slow_i,
  output logic       hs_en_o,
  output logic [1:0] recirc_o
);
  recirc_e rc;

  always_comb begin
    hs_en_o = hs_allow_i & pwm_i;
    if (hs_en_o)     rc = RC_NONE;
    else if (slow_i) rc = RC_SLOW;
    else             rc = RC_FAST;
  end

  assign recirc_o = rc;
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int CW        = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trip_i,
  input  logic          pwm_i,
  input  logic          slow_decay_i,
  input  logic [CW-1:0] off_cnt_i,
  input  logic [CW-1:0] blank_cnt_i,
  output logic          hs_en_o,
  output logic [1:0]    recirc_o,
  output logic [1:0]    state_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  chop_st_e      state_q, state_d;
  logic          trip_s;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] off_ld, blank_ld;

  // zero behaves as one: load value is max(n,1)-1
  assign off_ld   = (off_cnt_i   == '0) ? '0 : off_cnt_i   - ONE;
  assign blank_ld = (blank_cnt_i == '0) ? '0 : blank_cnt_i - ONE;

  chop_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_i),
    .q_o   (trip_s)
  );

  chop_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = blank_ld;
    unique case (state_q)
      ST_BLANK: begin
        if (!pwm_i)        tmr_load = 1'b1;
        else if (tmr_zero) state_d  = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (!pwm_i) begin
          state_d  = ST_BLANK;
          tmr_load = 1'b1;
        end else if (trip_s) begin
          state_d  = ST_OFF;
          tmr_load = 1'b1;
          tmr_val  = off_ld;
        end
      end
      ST_OFF: begin
        if (tmr_zero) begin
          state_d  = ST_BLANK;
          tmr_load = 1'b1;
        end
      end
      default: begin
        state_d  = ST_BLANK;
        tmr_load = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_BLANK;
    else         state_q <= state_d;
  end

  chop_out u_out (
    .hs_allow_i(state_q != ST_OFF),
    .pwm_i     (pwm_i),
    .slow_i    (slow_decay_i),
    .hs_en_o   (hs_en_o),
    .recirc_o  (recirc_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/chop_chk.sv
module chop_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwm_i,
  input logic       slow_decay_i,
  input logic       hs_en_o,
  input logic [1:0] recirc_o,
  input logic [1:0] state_o,
  input logic       trip_s,
  input logic       tmr_zero
);
  a_r1_trip_to_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && pwm_i && trip_s) |=> state_o == 2'b01);

  a_r2_off_hs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01) |-> !hs_en_o);

  a_r2_off_exit_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && tmr_zero) |=> state_o == 2'b10);

  a_r3_blank_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && pwm_i && !tmr_zero) |=> state_o == 2'b10);

  a_r4_pwm_low_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_i && state_o != 2'b01) |=> state_o == 2'b10);

  a_r5_recirc_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_en_o && slow_decay_i) |-> recirc_o == 2'b10);

  a_r5_recirc_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_en_o && !slow_decay_i) |-> recirc_o == 2'b01);

  a_r5_recirc_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> recirc_o == 2'b00);

  a_r6_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
endmodule

bind chop_ctrl chop_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_i       (pwm_i),
  .slow_decay_i(slow_decay_i),
  .hs_en_o     (hs_en_o),
  .recirc_o    (recirc_o),
  .state_o     (state_o),
  .trip_s      (trip_s),
  .tmr_zero    (tmr_zero)
);

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trip = 1'b0, pwm = 1'b0, slow = 1'b0;
  logic [CW-1:0] offc = 16'd4, blkc = 16'd3;
  logic          hs;
  logic [1:0]    rc, st;

  always #2 clk = ~clk;

  chop_ctrl #(.CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .pwm_i(pwm),
    .slow_decay_i(slow), .off_cnt_i(offc), .blank_cnt_i(blkc),
    .hs_en_o(hs), .recirc_o(rc), .state_o(st)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference model: phases 0 drive, 1 off-time, 2 blanking; rem = cycles left
  int m_s1, m_s2, m_st, m_rem;
  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic int exp_hs();
    return (pwm && m_st != 1) ? 1 : 0;
  endfunction
  function automatic int exp_rc();
    if (exp_hs() == 1) return 0;
    return slow ? 2 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_st <= 2; m_rem <= 1;
    end else begin
      m_s1 <= int'(trip);
      m_s2 <= m_s1;
      case (m_st)
        2: if (!pwm) m_rem <= eff(int'(blkc));
           else if (m_rem == 1) m_st <= 0;
           else m_rem <= m_rem - 1;
        0: if (!pwm) begin m_st <= 2; m_rem <= eff(int'(blkc)); end
           else if (m_s2 != 0) begin m_st <= 1; m_rem <= eff(int'(offc)); end
        default: if (m_rem == 1) begin m_st <= 2; m_rem <= eff(int'(blkc)); end
                 else m_rem <= m_rem - 1;
      endcase
    end
  end

  // continuous comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R1 hs_en", int'(hs), exp_hs());
      chk("R5 recirc", int'(rc), exp_rc());
      chk("R6 state", int'(st), m_st);
    end
  end

  task automatic wait_state(int s);
    while (int'(st) != s) begin @(posedge clk); #1; end
  endtask

  task automatic trip_window(int off_n, int blk_n, string tag_off, string tag_blk);
    int n;
    wait_state(0);
    @(negedge clk);
    trip = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
      if (n == 1) trip = 1'b0;
    end while (hs && n < 10);
    chk("R1 trip latency", n, 3);
    n = 0;
    while (int'(st) == 1 && n < 100) begin n++; @(posedge clk); #1; end
    chk(tag_off, n, off_n);
    n = 0;
    while (int'(st) == 2 && n < 100) begin n++; @(posedge clk); #1; end
    chk(tag_blk, n, blk_n);
    chk("R3 drive after blank", int'(st), 0);
  endtask

  initial begin
    int seed, n_off;
    seed = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    chk("R7 reset state", int'(st), 2);
    chk("R7 reset hs", int'(hs), 0);
    pwm = 1'b1;
    #1 chk("R7 hs follows pwm", int'(hs), 1);
    @(negedge clk);
    pwm = 1'b0;
    rst_n = 1'b1;

    // off and blank lengths
    @(negedge clk);
    offc = 16'd7; blkc = 16'd5; pwm = 1'b1;
    trip_window(7, 5, "R2 off length", "R3 blank length");

    // zero counts behave as one
    offc = 16'd0; blkc = 16'd0;
    trip_window(1, 1, "R8 zero off", "R8 zero blank");

    // trips during blanking ignored
    @(negedge clk);
    blkc = 16'd12; pwm = 1'b0;
    repeat (2) @(negedge clk);
    pwm = 1'b1; trip = 1'b1;
    repeat (6) @(negedge clk);
    trip = 1'b0;
    n_off = 0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      if (int'(st) == 1) n_off++;
    end
    chk("R3 blank ignores trip", n_off, 0);
    chk("R3 drive reached", int'(st), 0);

    // pwm low gating and decay codes
    @(negedge clk);
    pwm = 1'b0; slow = 1'b1;
    #1 chk("R4 pwm low hs", int'(hs), 0);
    chk("R5 slow code", int'(rc), 2);
    slow = 1'b0;
    #1 chk("R5 fast code", int'(rc), 1);
    @(posedge clk); #1;
    chk("R4 pwm low blank", int'(st), 2);

    // constrained random
    @(negedge clk);
    offc = 16'd3; blkc = 16'd2; pwm = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      trip = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) pwm = ~pwm;
      if (($urandom % 100) == 0) slow = ~slow;
      if (($urandom % 50) == 0) offc = CW'($urandom % 12);
      if (($urandom % 50) == 0) blkc = CW'($urandom % 12);
    end
    @(negedge clk);
    trip = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule